// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bit-level slave side of a two-wire (I2C) serial memory holding 1024 bytes. It runs on a system clock and oversamples the serial clock and data lines through two-flop synchronizers. From the synchronized samples it finds START and STOP conditions and shifts in the device-address, memory-address and data bytes. It answers each byte with ACK or NoACK on an active-high pull-down output that a pad would turn into an open-drain drive. The system clock must run at least sixteen times faster than the serial clock.

Reads come straight from a synchronous RAM whose read address is the block's exposed address register, so the RAM's data is always ready before it is needed. Write bytes are not stored here. Each accepted byte is handed to a page-write controller as an address and data pair. A commit pulse on STOP tells that controller to start its internal write cycle, and the controller reports that cycle back through a busy input. While busy is high the block refuses its device address, so a master can poll for completion. A write-protect level, sampled at one fixed clock edge, can refuse a whole write. The two upper memory-address bits travel inside the device-address byte, so no pins select the device.

Top module: `i2c_ee_slave`

## Requirements
- R1: Until a START has been seen, clocking bits on the bus has no effect: the block never pulls the data line and never forwards a byte.
- R2: A device-address byte is acknowledged only when bits 7..4 are 1010 and bit 3 is 0. Any other value gets NoACK, and the block then ignores the bus until the next START or STOP.
- R3: START is data falling while the clock is high. STOP is data rising while the clock is high. Each STOP gives exactly one `stop_o` pulse.
- R4: The pull-down output changes only while the synchronized clock is low. Read data goes out most significant bit first, and a pull-down means a 0 bit.
- R5: In a write (bit 0 = 0), the memory-address byte is acknowledged. Every following data byte is acknowledged and forwarded with address {device bits 2:1, address byte} and its data.
- R6: Within one write, the forwarding address steps through the low four bits only. It wraps inside its 16-byte page and never leaves it.
- R7: While `wr_busy_i` is high at the device-address acknowledge, the device address gets NoACK.
- R8: `wp_i` is sampled on the falling clock edge that ends the memory-address acknowledge. If it was high, the first data byte gets NoACK, nothing is forwarded and no commit follows.
- R9: A read (bit 0 = 1) straight after START returns the byte at the exposed current address. The high bits of the read device byte do not change that address.
- R10: During a read the address advances by one after every byte sent and wraps from 0x3FF to 0x000. A master ACK brings out the next byte, and a master NoACK releases the bus.
- R11: `wb_commit_o` pulses, together with `stop_o`, only on a STOP that ends a write in which at least one data byte was accepted. A START or STOP in the middle of a byte aborts the transfer, and a repeated START drops pending data.
- R12: A selective read is a write of the address bytes, then a repeated START with a read device byte. It returns the data at the selected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| wp_i | input | 1 | Write-protect level |
| wr_busy_i | input | 1 | Page controller internal write cycle in progress |
| rd_data_i | input | 8 | Synchronous RAM read data for `cur_addr_o` |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cur_addr_o | output | AW | Internal address register, also the RAM read address |
| wb_valid_o | output | 1 | One-cycle pulse: a write byte was accepted |
| wb_addr_o | output | AW | Address of the forwarded byte |
| wb_data_o | output | 8 | Forwarded data byte |
| wb_commit_o | output | 1 | One-cycle pulse: start the internal write cycle |
| stop_o | output | 1 | One-cycle pulse per detected STOP |

## Verification
The bench targets three kinds of error. It runs page writes that wrap inside a page and reads that wrap at the top of memory. A design that carries into the page bits would write into the neighbouring page, and one that stops at 0x3FF would return the wrong byte. It raises write-protect, polls the device address while busy, and ends a write with a STOP in the middle of a byte. A design that samples write-protect at the wrong edge, acknowledges while busy, or commits an empty or aborted write would ACK the wrong byte or start a spurious write cycle. Random single- and multi-byte writes, each read back through a selective read, catch any slip in the bit order or in the acknowledge slot.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    M_IDLE, // no START seen yet
    M_DEV,  // receiving device-address byte
    M_ADDR, // receiving memory-address byte
    M_WR,   // receiving data bytes
    M_RD,   // transmitting data bytes
    M_IGN   // refused: wait for START or STOP
  } mode_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] synced;
  logic       scl_q, sda_q;

  i2c_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({scl_i, sda_i}),
    .q_o  (synced)
  );

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int AW   = 10,
  parameter int PAGE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic [7:0]    lo_i,
  input  logic          ld_hi,
  input  logic [AW-9:0] hi_i,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] addr_o
);
  localparam int PB = $clog2(PAGE);

  logic [AW-1:0] addr_q, addr_n;
  logic [PB-1:0] page_low;

  assign page_low = addr_q[PB-1:0] + PB'(1);

  always_comb begin
    addr_n = addr_q;
    if (ld_lo)    addr_n[7:0]    = lo_i;
    if (ld_hi)    addr_n[AW-1:8] = hi_i;
    if (inc_full) addr_n         = addr_q + AW'(1);
    if (inc_page) addr_n[PB-1:0] = page_low;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_n;

  assign addr_o = addr_q;
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter int         AW          = 10,
  parameter int         PAGE        = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'hA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          wp_i,
  input  logic          wr_busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          wb_valid_o,
  output logic [AW-1:0] wb_addr_o,
  output logic [7:0]    wb_data_o,
  output logic          wb_commit_o,
  output logic          stop_o
);
  localparam int HB = AW - 8;
  localparam int PB = $clog2(PAGE);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  mode_e       mode_q, mode_n;
  logic [3:0]  bit_q, bit_n;
  logic [7:0]  sh_q, sh_n, tx_q, tx_n;
  logic        oe_q, oe_n, rnw_q, rnw_n, wp_q, wp_n;
  logic        seen_q, seen_n, mack_q, mack_n;
  logic        wv_n, cm_n, st_n;
  logic        ld_lo, ld_hi, inc_page, inc_full;
  logic [2:0]  tx_idx;
  logic [1:0]  dev_hi;
  logic        dev_ok;

  assign tx_idx = 3'(4'd7 - bit_q);
  assign dev_hi = sh_q[2:1];
  assign dev_ok = (sh_q[7:4] == DEV_CODE) && !sh_q[3] && !wr_busy_i;

  i2c_addr_ctr #(.AW(AW), .PAGE(PAGE)) u_actr (
    .clk(clk), .rst_n(rst_n),
    .ld_lo(ld_lo), .lo_i(sh_q),
    .ld_hi(ld_hi), .hi_i(dev_hi[HB-1:0]),
    .inc_page(inc_page), .inc_full(inc_full),
    .addr_o(cur_addr_o)
  );

  always_comb begin
    mode_n = mode_q;  bit_n = bit_q;  sh_n = sh_q;  tx_n = tx_q;
    oe_n = oe_q;  rnw_n = rnw_q;  wp_n = wp_q;  seen_n = seen_q;  mack_n = mack_q;
    wv_n = 1'b0;  cm_n = 1'b0;  st_n = 1'b0;
    ld_lo = 1'b0;  ld_hi = 1'b0;  inc_page = 1'b0;  inc_full = 1'b0;
    if (stop_det) begin
      st_n = 1'b1;  cm_n = seen_q;  seen_n = 1'b0;
      mode_n = M_IDLE;  oe_n = 1'b0;  bit_n = '0;
    end else if (start_det) begin
      mode_n = M_DEV;  oe_n = 1'b0;  bit_n = '0;  seen_n = 1'b0;
    end else if (mode_q != M_IDLE && mode_q != M_IGN) begin
      if (scl_rise) begin
        if (bit_q < 4'd9) bit_n = bit_q + 4'd1;
        if (bit_q < 4'd8) sh_n = {sh_q[6:0], sda_s};
        if (bit_q == 4'd8 && mode_q == M_RD) mack_n = !sda_s;
      end
      if (scl_fall) begin
        if (bit_q == 4'd8) begin
          unique case (mode_q)
            M_RD: begin oe_n = 1'b0; inc_full = 1'b1; end
            M_DEV: begin
              if (dev_ok) begin
                oe_n = 1'b1;  rnw_n = sh_q[0];  ld_hi = !sh_q[0];
              end else begin
                oe_n = 1'b0;  mode_n = M_IGN;
              end
            end
            M_ADDR: begin oe_n = 1'b1; ld_lo = 1'b1; end
            M_WR: begin
              if (wp_q) begin
                oe_n = 1'b0;  mode_n = M_IGN;
              end else begin
                oe_n = 1'b1;  wv_n = 1'b1;  inc_page = 1'b1;  seen_n = 1'b1;
              end
            end
            default: ;
          endcase
        end else if (bit_q == 4'd9) begin
          oe_n = 1'b0;  bit_n = '0;
          unique case (mode_q)
            M_DEV: begin
              if (rnw_q) begin
                mode_n = M_RD;  tx_n = rd_data_i;  oe_n = !rd_data_i[7];
              end else mode_n = M_ADDR;
            end
            M_ADDR: begin mode_n = M_WR; wp_n = wp_i; end
            M_RD: begin
              if (mack_q) begin
                tx_n = rd_data_i;  oe_n = !rd_data_i[7];
              end else mode_n = M_IGN;
            end
            default: ;
          endcase
        end else if (mode_q == M_RD) begin
          oe_n = !tx_q[tx_idx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= M_IDLE;  bit_q <= '0;  sh_q <= '0;  tx_q <= '0;
      oe_q <= 1'b0;  rnw_q <= 1'b0;  wp_q <= 1'b0;  seen_q <= 1'b0;  mack_q <= 1'b0;
      wb_valid_o <= 1'b0;  wb_addr_o <= '0;  wb_data_o <= '0;
      wb_commit_o <= 1'b0;  stop_o <= 1'b0;
    end else begin
      mode_q <= mode_n;  bit_q <= bit_n;  sh_q <= sh_n;  tx_q <= tx_n;
      oe_q <= oe_n;  rnw_q <= rnw_n;  wp_q <= wp_n;  seen_q <= seen_n;  mack_q <= mack_n;
      wb_valid_o <= wv_n;  wb_commit_o <= cm_n;  stop_o <= st_n;
      if (wv_n) begin
        wb_addr_o <= cur_addr_o;
        wb_data_o <= sh_q;
      end
    end

  assign sda_pull_o = oe_q;

  // R4: pull-down starts only while the synchronized clock is low
  a_r4_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  // R7: the device-address ACK is never given while the write cycle is busy
  a_r7_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) && mode_q == M_DEV) |-> !$past(wr_busy_i));

  // R6: a forwarded byte and the stepped address stay in one page
  a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> (cur_addr_o[AW-1:PB] == wb_addr_o[AW-1:PB]));

  // R10: a read step out of the top address lands on zero
  a_r10_addr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_RD && $past(cur_addr_o) == {AW{1'b1}} &&
     cur_addr_o != $past(cur_addr_o)) |-> cur_addr_o == '0);

  // R11: a commit pulse only comes with a STOP pulse
  a_r11_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wb_commit_o |-> stop_o);
endmodule

// File: tb/i2c_ee_slave_tb.sv
module i2c_ee_slave_tb;
  logic clk, rst_n, scl, sda_m, wp, busy;
  logic [7:0] rdat;
  logic sda_pull, wb_valid, wb_commit, stop_p;
  logic [9:0] cur_addr, wb_addr;
  logic [7:0] wb_data;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_ee_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .wp_i(wp),
    .wr_busy_i(busy), .rd_data_i(rdat), .sda_pull_o(sda_pull),
    .cur_addr_o(cur_addr), .wb_valid_o(wb_valid), .wb_addr_o(wb_addr),
    .wb_data_o(wb_data), .wb_commit_o(wb_commit), .stop_o(stop_p)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_commit = 0, n_stop = 0, busy_cnt = 0;
  bit pulled_seen = 0;
  logic [7:0] ram [1024];
  logic [7:0] shadow [1024];
  logic [9:0] pb_addr [64];
  logic [7:0] pb_data [64];
  int pb_n = 0;
  logic [7:0] wdat [16];
  logic [9:0] last_wb_addr [16];

  // stand-in synchronous RAM and page-write controller
  always @(posedge clk) begin
    rdat <= ram[cur_addr];
    if (sda_pull) pulled_seen <= 1;
    if (wb_valid) begin
      if (n_valid < 16) last_wb_addr[n_valid] <= wb_addr;
      pb_addr[pb_n % 64] <= wb_addr;  pb_data[pb_n % 64] <= wb_data;
      pb_n <= pb_n + 1;  n_valid <= n_valid + 1;
    end
    if (stop_p) n_stop <= n_stop + 1;
    if (wb_commit) begin
      for (int i = 0; i < pb_n && i < 64; i++) ram[pb_addr[i]] = pb_data[i];
      n_commit <= n_commit + 1;  busy <= 1'b1;  busy_cnt <= 400;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) busy <= 1'b0;
    end
    if (stop_p) pb_n <= 0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (8) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; q(); scl = 1; q(); sda_m = 0; q(); scl = 0; q();
  endtask

  task automatic bus_stop();
    sda_m = 0; q(); scl = 1; q(); sda_m = 1; q();
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; q(); scl = 1; q(); q(); scl = 0; q();
  endtask

  task automatic tx(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) tx_bit(b[i]);
    sda_m = 1; q(); scl = 1; q(); ack = !sda_bus; q(); scl = 0; q();
  endtask

  task automatic rx(input logic mack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; q(); scl = 1; q(); b = {b[6:0], sda_bus}; q(); scl = 0; q();
    end
    sda_m = !mack; q(); scl = 1; q(); q(); scl = 0; q(); sda_m = 1;
  endtask

  function automatic logic [7:0] devb(input logic [9:0] a, input logic rnw);
    return {4'hA, 1'b0, a[9:8], rnw};
  endfunction

  function automatic logic [9:0] pg(input logic [9:0] a, input int i);
    return {a[9:4], 4'(a[3:0] + 4'(i))};
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    q();
  endtask

  task automatic do_write(input logic [9:0] a, input int n, input string tag);
    logic ack;
    int c0 = n_commit;
    bus_start();
    tx(devb(a, 0), ack); check({tag, " dev ack"}, ack, 1);
    tx(a[7:0], ack);     check({tag, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      tx(wdat[i], ack);  check({tag, " data ack"}, ack, 1);
      shadow[pg(a, i)] = wdat[i];
    end
    bus_stop(); q();
    check({tag, " commit"}, n_commit - c0, 1);
    wait_idle();
  endtask

  task automatic sel_read(input logic [9:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    tx(devb(a, 0), ack);
    tx(a[7:0], ack);
    bus_start();
    tx(devb(a, 1), ack); check({tag, " read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rx(i != n - 1, b);
      check({tag, " read data"}, b, shadow[10'(a + 10'(i))]);
    end
    bus_stop(); q();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int c0, s0, v0;
    logic [9:0] ra;
    int rn;
    for (int i = 0; i < 1024; i++) begin ram[i] = 8'hFF; shadow[i] = 8'hFF; end
    void'($urandom(32'd4242));
    scl = 1; sda_m = 1; wp = 0; busy = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1; q();
    check("reset pull", sda_pull, 0);
    check("reset addr", cur_addr, 0);
    check("reset commit", wb_commit, 0);

    // R1: bits without START are ignored
    tx(devb(10'h000, 0), ack);
    tx(8'h12, ack);
    check("R1 no ack without start", ack, 0);
    check("R1 never pulled", pulled_seen, 0);
    check("R1 nothing forwarded", n_valid, 0);

    // R2: wrong device code and set bit 3 are refused
    bus_start(); tx(8'hB0, ack); bus_stop(); q();
    check("R2 wrong code nack", ack, 0);
    bus_start(); tx(8'hA8, ack); bus_stop(); q();
    check("R2 bit3 set nack", ack, 0);
    check("R3 stop pulses", n_stop, 2);

    // R5, R6: page write wrapping inside the page
    for (int i = 0; i < 4; i++) wdat[i] = 8'h30 + 8'(i);
    v0 = n_valid;
    bus_start();
    tx(devb(10'h10E, 0), ack); tx(8'h0E, ack);
    for (int i = 0; i < 4; i++) begin tx(wdat[i], ack); shadow[pg(10'h10E, i)] = wdat[i]; end
    bus_stop(); q();
    check("R5 forwarded count", n_valid - v0, 4);
    check("R5 first addr", last_wb_addr[0], 10'h10E);
    check("R6 wrapped addr", last_wb_addr[2], 10'h100);
    check("R6 cur addr in page", cur_addr, 10'h102);

    // R7: polling while busy
    bus_start(); tx(devb(0, 0), ack); bus_stop(); q();
    check("R7 busy nack", ack, 0);
    wait_idle();
    bus_start(); tx(devb(0, 0), ack); bus_stop(); q();
    check("R7 idle ack", ack, 1);

    // R12, R4: selective read of the wrapped page, MSB first
    sel_read(10'h100, 2, "R12 R4");
    sel_read(10'h10E, 2, "R12");

    // R8: write protect refuses the first data byte
    wp = 1; c0 = n_commit; v0 = n_valid;
    bus_start(); tx(devb(10'h055, 0), ack); tx(8'h55, ack);
    tx(8'h99, ack); bus_stop(); q();
    wp = 0;
    check("R8 data nack", ack, 0);
    check("R8 no forward", n_valid - v0, 0);
    check("R8 no commit", n_commit - c0, 0);
    sel_read(10'h055, 1, "R8 unchanged");

    // R10: sequential read wrapping at the top
    wdat[0] = 8'hC1; wdat[1] = 8'hC2; do_write(10'h3FE, 2, "R10 setup");
    wdat[0] = 8'hC3; do_write(10'h000, 1, "R10 setup");
    wdat[0] = 8'hC4; do_write(10'h001, 1, "R10 setup");
    sel_read(10'h3FE, 3, "R10 wrap");
    check("R10 addr after wrap", cur_addr, 10'h001);

    // R9: current address read
    bus_start(); tx(devb(10'h300, 1), ack); rx(0, b); bus_stop(); q();
    check("R9 ack", ack, 1);
    check("R9 data", b, shadow[1]);
    check("R9 addr advanced", cur_addr, 10'h002);

    // R11: STOP mid-byte after the address, and repeated START after data
    c0 = n_commit; s0 = n_stop;
    bus_start(); tx(devb(10'h200, 0), ack); tx(8'h00, ack);
    for (int i = 0; i < 4; i++) tx_bit(1'b1);
    bus_stop(); q();
    check("R11 no commit mid-byte stop", n_commit - c0, 0);
    check("R11 stop seen", n_stop - s0, 1);
    bus_start(); tx(devb(10'h200, 0), ack); tx(8'h00, ack); tx(8'h77, ack);
    bus_start(); tx(devb(10'h200, 1), ack); rx(0, b); bus_stop(); q();
    check("R11 no commit after restart", n_commit - c0, 0);
    check("R11 dropped data", b, shadow[10'h201]);

    // random writes with read-back
    for (int k = 0; k < 6; k++) begin
      ra = 10'($urandom % 1024);
      rn = 1 + int'($urandom % 4);
      for (int i = 0; i < rn; i++) wdat[i] = 8'($urandom);
      do_write(ra, rn, "R5 random");
      for (int i = 0; i < rn; i++) sel_read(pg(ra, i), 1, "R12 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule